// File: doc/BRIEF.md
# Speculation-Aware Reorder Buffer

This block keeps every in-flight instruction in program order, from the moment it is dispatched until it leaves the machine. It is a circular queue. Up to `DISP_W` new entries are claimed at the tail in one cycle, and the index of each claimed slot is returned to the dispatcher. Execution units report back through an issue-status port and a finish port. Each entry moves from waiting to executing to finished.

Every entry holds a branch mask. Each bit of the mask stands for one unresolved branch that the instruction was fetched under. When a branch resolves, its bit is cleared in every entry. On a misprediction, every entry that held the bit is also marked squashed.

Up to `CMPL_W` entries leave the head in one cycle, in strict order. Each leaving entry presents its destination rename tag, so the register write-back logic can release that rename register. A squashed entry still leaves through a completion lane, but with its write flag low.

Top module: `spec_rob`

## Requirements
- R1: After reset the queue is empty. No completion lane is valid, and a request for any lane count up to `DISP_W` is accepted.
- R2: Accepted allocation lanes, counted from lane 0, receive consecutive entry indices starting at the tail. The indices wrap modulo `ROB_DEPTH`.
- R3: `allocReady` is low whenever the free-entry count is smaller than the number of asserted `allocValid` bits. In that case nothing is allocated and the tail does not move. A request that exactly fills the remaining space is accepted.
- R4: An entry in the waiting or executing state does not complete. Status codes are waiting=0, executing=1 and finished=2. An issue report moves waiting to executing, and a finish report moves the entry to finished.
- R5: Completion is in program order. A younger finished entry does not complete while an older entry ahead of it does not qualify.
- R6: Each cycle, completion takes the longest qualifying run of entries from the head, up to `CMPL_W` entries. Lane k carries the k-th oldest entry, and the lanes that are valid form a prefix starting at lane 0.
- R7: A finished entry with any mask bit set does not complete. A correct resolution (`brMispredict`=0) clears the one-hot `brMask` bit in every entry, which frees those entries to complete.
- R8: A mispredicted resolution (`brMispredict`=1) squashes every entry holding the `brMask` bit, whatever its status. Squashed entries complete from the head with `retWrite` low, and each one takes one completion lane of the per-cycle budget.
- R9: Each completion lane presents, on `retTag`, the rename tag that was supplied when its entry was allocated. Entries leave in the same order they were allocated.
- R10: All `ROB_DEPTH` entries can be occupied at once. A full queue is told apart from an empty one, and refuses any further allocation.
- R11: A branch resolution that arrives in the same cycle as an allocation also applies to the entries being written in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocValid | input | DISP_W | One bit per allocation lane that requests an entry |
| allocTag | input | DISP_W*RTAG_W | Destination rename tag for each allocation lane |
| allocMask | input | DISP_W*BMASK_W | Branch mask for each allocation lane |
| allocReady | output | 1 | Enough free entries exist for the current request |
| allocIdx | output | DISP_W*IDX_W | Entry index that each allocation lane receives |
| issueValid | input | 1 | Issue-status report is valid |
| issueIdx | input | IDX_W | Entry that has started executing |
| finishValid | input | 1 | Finish report is valid |
| finishIdx | input | IDX_W | Entry that has finished executing |
| brValid | input | 1 | Branch resolution is valid |
| brMask | input | BMASK_W | One-hot bit of the branch being resolved |
| brMispredict | input | 1 | High when the resolved branch was mispredicted |
| retValid | output | CMPL_W | Completion lane carries an entry leaving the head |
| retTag | output | CMPL_W*RTAG_W | Rename tag released by each completion lane |
| retWrite | output | CMPL_W | Lane needs an architectural write; low for a squashed entry |

## Verification
The assertions assume the following about the inputs:
- Issue and finish reports name only entries that are currently in flight.
- `brMask` is one-hot and names a branch that is still outstanding.
- A finish report never arrives before the entry is allocated.

The stimulus stays within these limits. It computes every index it reports from its own model of the tail, and it resolves each mask bit exactly once, after the entries that carry it exist. The one exception is the same-cycle case of R11, where the resolution arrives together with the allocation it applies to.

// File: rtl/spec_rob_pkg.sv
package spec_rob_pkg;
  parameter int ROB_DEPTH = 8;
  parameter int DISP_W    = 2;
  parameter int CMPL_W    = 2;
  parameter int RTAG_W    = 5;
  parameter int BMASK_W   = 4;

  localparam int IDX_W = $clog2(ROB_DEPTH);
  localparam int PTR_W = IDX_W + 1;

  typedef logic [IDX_W-1:0] robIdx_t;
  typedef logic [PTR_W-1:0] robPtr_t;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_EXEC = 2'd1,
    ST_DONE = 2'd2
  } robStat_e;

  // strobes from control to the entry storage
  typedef struct packed {
    logic [DISP_W-1:0]          allocWe;
    robIdx_t [DISP_W-1:0]       allocPos;
    logic [CMPL_W-1:0]          retWe;
    robIdx_t [CMPL_W-1:0]       retPos;
  } robStrobe_t;
endpackage

// File: rtl/spec_rob_ctrl.sv
module spec_rob_ctrl
  import spec_rob_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DISP_W-1:0]       allocValid,
  input  logic [ROB_DEPTH-1:0]    retireOk,
  output logic                    allocReady,
  output logic [DISP_W*IDX_W-1:0] allocIdx,
  output robStrobe_t              strobe
);
  robPtr_t headQ, tailQ;
  robPtr_t used, freeCnt, reqCnt, retCnt;
  logic    chain;
  robIdx_t pos;

  // wrap bit on each pointer makes full and empty distinct
  assign used    = tailQ - headQ;
  assign freeCnt = PTR_W'(ROB_DEPTH) - used;

  always_comb begin
    reqCnt = '0;
    for (int k = 0; k < DISP_W; k++) begin
      strobe.allocPos[k] = tailQ[IDX_W-1:0] + reqCnt[IDX_W-1:0];
      allocIdx[k*IDX_W +: IDX_W] = strobe.allocPos[k];
      if (allocValid[k]) reqCnt = reqCnt + 1'b1;
    end
    allocReady = (freeCnt >= reqCnt);
    for (int k = 0; k < DISP_W; k++)
      strobe.allocWe[k] = allocValid[k] & allocReady;
  end

  always_comb begin
    chain  = 1'b1;
    retCnt = '0;
    for (int k = 0; k < CMPL_W; k++) begin
      pos   = headQ[IDX_W-1:0] + IDX_W'(k);
      chain = chain && (PTR_W'(k) < used) && retireOk[pos];
      strobe.retWe[k]  = chain;
      strobe.retPos[k] = pos;
      if (chain) retCnt = retCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ <= '0;
      tailQ <= '0;
    end else begin
      headQ <= headQ + retCnt;
      tailQ <= tailQ + (allocReady ? reqCnt : '0);
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    used <= PTR_W'(ROB_DEPTH));

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid != '0 && !allocReady) |=> tailQ == $past(tailQ));

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.retWe[0] |-> used != '0);
endmodule

// File: rtl/spec_rob_dpath.sv
module spec_rob_dpath
  import spec_rob_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  robStrobe_t                strobe,
  input  logic [DISP_W*RTAG_W-1:0]  allocTag,
  input  logic [DISP_W*BMASK_W-1:0] allocMask,
  input  logic                      issueValid,
  input  robIdx_t                   issueIdx,
  input  logic                      finishValid,
  input  robIdx_t                   finishIdx,
  input  logic                      brValid,
  input  logic [BMASK_W-1:0]        brMask,
  input  logic                      brMispredict,
  output logic [ROB_DEPTH-1:0]      retireOk,
  output logic [CMPL_W*RTAG_W-1:0]  retTag,
  output logic [CMPL_W-1:0]         retWrite
);
  robStat_e           statQ [ROB_DEPTH];
  logic               badQ  [ROB_DEPTH];
  logic [BMASK_W-1:0] maskQ [ROB_DEPTH];
  logic [RTAG_W-1:0]  tagQ  [ROB_DEPTH];

  robStat_e           statN [ROB_DEPTH];
  logic               badN  [ROB_DEPTH];
  logic [BMASK_W-1:0] maskN [ROB_DEPTH];
  logic [RTAG_W-1:0]  tagN  [ROB_DEPTH];
  logic [ROB_DEPTH-1:0] allocHit;
  logic [BMASK_W-1:0]   maskOr;

  always_comb begin
    maskOr = '0;
    for (int e = 0; e < ROB_DEPTH; e++) begin
      statN[e] = statQ[e];
      badN[e]  = badQ[e];
      maskN[e] = maskQ[e];
      tagN[e]  = tagQ[e];
      allocHit[e] = 1'b0;
      for (int k = 0; k < DISP_W; k++) begin
        if (strobe.allocWe[k] && strobe.allocPos[k] == robIdx_t'(e)) begin
          allocHit[e] = 1'b1;
          statN[e] = ST_WAIT;
          badN[e]  = 1'b0;
          maskN[e] = allocMask[k*BMASK_W +: BMASK_W];
          tagN[e]  = allocTag[k*RTAG_W +: RTAG_W];
        end
      end
      if (!allocHit[e]) begin
        if (issueValid && issueIdx == robIdx_t'(e) && statQ[e] == ST_WAIT)
          statN[e] = ST_EXEC;
        if (finishValid && finishIdx == robIdx_t'(e))
          statN[e] = ST_DONE;
      end
      // resolution also covers entries written this cycle
      if (brValid) begin
        if (brMispredict && |(maskN[e] & brMask)) badN[e] = 1'b1;
        maskN[e] = maskN[e] & ~brMask;
      end
      retireOk[e] = badQ[e] | (statQ[e] == ST_DONE && maskQ[e] == '0);
      maskOr = maskOr | maskQ[e];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ROB_DEPTH; e++) begin
        statQ[e] <= ST_WAIT;
        badQ[e]  <= 1'b0;
        maskQ[e] <= '0;
        tagQ[e]  <= '0;
      end
    end else begin
      for (int e = 0; e < ROB_DEPTH; e++) begin
        statQ[e] <= statN[e];
        badQ[e]  <= badN[e];
        maskQ[e] <= maskN[e];
        tagQ[e]  <= tagN[e];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < CMPL_W; k++) begin
      retTag[k*RTAG_W +: RTAG_W] = tagQ[strobe.retPos[k]];
      retWrite[k] = strobe.retWe[k] & ~badQ[strobe.retPos[k]];
    end
  end

  p_clear_on_resolve_r7: assert property (@(posedge clk) disable iff (!rstN)
    brValid |=> (maskOr & $past(brMask)) == '0);

  for (genvar e = 0; e < ROB_DEPTH; e++) begin : g_entryChk
    p_sticky_squash_r8: assert property (@(posedge clk) disable iff (!rstN)
      (badQ[e] && !allocHit[e]) |=> badQ[e]);
    p_sticky_done_r4: assert property (@(posedge clk) disable iff (!rstN)
      (statQ[e] == ST_DONE && !allocHit[e]) |=> statQ[e] == ST_DONE);
  end
endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import spec_rob_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [DISP_W-1:0]         allocValid,
  input  logic [DISP_W*RTAG_W-1:0]  allocTag,
  input  logic [DISP_W*BMASK_W-1:0] allocMask,
  output logic                      allocReady,
  output logic [DISP_W*IDX_W-1:0]   allocIdx,
  input  logic                      issueValid,
  input  logic [IDX_W-1:0]          issueIdx,
  input  logic                      finishValid,
  input  logic [IDX_W-1:0]          finishIdx,
  input  logic                      brValid,
  input  logic [BMASK_W-1:0]        brMask,
  input  logic                      brMispredict,
  output logic [CMPL_W-1:0]         retValid,
  output logic [CMPL_W*RTAG_W-1:0]  retTag,
  output logic [CMPL_W-1:0]         retWrite
);
  robStrobe_t           strobe;
  logic [ROB_DEPTH-1:0] retireOk;

  spec_rob_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .allocValid (allocValid),
    .retireOk   (retireOk),
    .allocReady (allocReady),
    .allocIdx   (allocIdx),
    .strobe     (strobe)
  );

  spec_rob_dpath u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .allocTag     (allocTag),
    .allocMask    (allocMask),
    .issueValid   (issueValid),
    .issueIdx     (issueIdx),
    .finishValid  (finishValid),
    .finishIdx    (finishIdx),
    .brValid      (brValid),
    .brMask       (brMask),
    .brMispredict (brMispredict),
    .retireOk     (retireOk),
    .retTag       (retTag),
    .retWrite     (retWrite)
  );

  assign retValid = strobe.retWe;
endmodule

// File: tb/spec_rob_bench.sv
`timescale 1ns/1ps
module spec_rob_bench;
  import spec_rob_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                      rstN;
  logic [DISP_W-1:0]         allocValid;
  logic [DISP_W*RTAG_W-1:0]  allocTag;
  logic [DISP_W*BMASK_W-1:0] allocMask;
  logic                      allocReady;
  logic [DISP_W*IDX_W-1:0]   allocIdx;
  logic                      issueValid;
  logic [IDX_W-1:0]          issueIdx;
  logic                      finishValid;
  logic [IDX_W-1:0]          finishIdx;
  logic                      brValid;
  logic [BMASK_W-1:0]        brMask;
  logic                      brMispredict;
  logic [CMPL_W-1:0]         retValid;
  logic [CMPL_W*RTAG_W-1:0]  retTag;
  logic [CMPL_W-1:0]         retWrite;

  spec_rob u_spec_rob (.*);

  int checks = 0;
  int errors = 0;
  logic [RTAG_W:0] expQ [$];   // {write, tag} in program order

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    allocValid = '0; issueValid = 1'b0; finishValid = 1'b0; brValid = 1'b0;
  endtask

  task automatic alloc(int n, int t0, int t1, logic [BMASK_W-1:0] m0,
                       logic [BMASK_W-1:0] m1, bit w0, bit w1,
                       bit expReady, int expIdx);
    idle();
    allocValid[0] = 1'b1;
    allocTag[0 +: RTAG_W] = RTAG_W'(t0);
    allocMask[0 +: BMASK_W] = m0;
    if (n == 2) begin
      allocValid[1] = 1'b1;
      allocTag[RTAG_W +: RTAG_W] = RTAG_W'(t1);
      allocMask[BMASK_W +: BMASK_W] = m1;
    end
    #1;
    check(allocReady == expReady, "R3", "allocReady", allocReady, expReady);
    if (expReady) begin
      check(allocIdx[0 +: IDX_W] == IDX_W'(expIdx), "R2", "lane0 index",
            allocIdx[0 +: IDX_W], expIdx);
      expQ.push_back({w0, RTAG_W'(t0)});
      if (n == 2) begin
        check(allocIdx[IDX_W +: IDX_W] == IDX_W'((expIdx + 1) % ROB_DEPTH), "R2",
              "lane1 index", allocIdx[IDX_W +: IDX_W], (expIdx + 1) % ROB_DEPTH);
        expQ.push_back({w1, RTAG_W'(t1)});
      end
    end
  endtask

  task automatic doIssue(int idx);
    idle(); issueValid = 1'b1; issueIdx = IDX_W'(idx);
  endtask

  task automatic doFinish(int idx);
    idle(); finishValid = 1'b1; finishIdx = IDX_W'(idx);
  endtask

  task automatic resolve(logic [BMASK_W-1:0] m, bit mis);
    idle(); brValid = 1'b1; brMask = m; brMispredict = mis;
  endtask

  task automatic retCheck(logic [CMPL_W-1:0] exp, string req);
    idle(); #1;
    check(retValid == exp, req, "retValid", retValid, exp);
  endtask

  // scoreboard monitor: every completing lane must match the next expected item
  always @(negedge clk) begin
    if (rstN) begin
      for (int k = 0; k < CMPL_W; k++) begin
        if (retValid[k]) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R9", "unexpected completion lane", k, -1);
          end else begin
            logic [RTAG_W:0] e;
            e = expQ.pop_front();
            check(retTag[k*RTAG_W +: RTAG_W] == e[RTAG_W-1:0], "R9", "retTag",
                  retTag[k*RTAG_W +: RTAG_W], e[RTAG_W-1:0]);
            check(retWrite[k] == e[RTAG_W], "R8", "retWrite", retWrite[k], e[RTAG_W]);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    allocValid = '0; allocTag = '0; allocMask = '0;
    issueValid = 1'b0; issueIdx = '0; finishValid = 1'b0; finishIdx = '0;
    brValid = 1'b0; brMask = '0; brMispredict = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    check(retValid == '0, "R1", "retValid after reset", retValid, 0);
    check(allocReady == 1'b1, "R1", "allocReady after reset", allocReady, 1);

    // R1 full-width request on empty queue, R2 indices from 0
    alloc(2, 1, 2, '0, '0, 1, 1, 1, 0);
    retCheck('0, "R4");                 // both waiting
    doIssue(0);
    retCheck('0, "R4");                 // executing blocks
    doFinish(1);
    retCheck('0, "R5");                 // younger finished, head not
    doFinish(0);
    retCheck(2'b11, "R6");              // two in one cycle

    // fill to full with wrap (R10), speculative pairs
    alloc(2, 10, 11, 4'b0000, 4'b0000, 1, 1, 1, 2);
    alloc(2, 12, 13, 4'b0001, 4'b0001, 1, 1, 1, 4);
    alloc(2, 14, 15, 4'b0010, 4'b0010, 0, 0, 1, 6);
    alloc(2, 16, 17, 4'b0000, 4'b0000, 1, 1, 1, 0);  // exact fit, R3 boundary
    alloc(1, 30, 0, '0, '0, 1, 0, 0, 0);             // R10 full refuses
    for (int i = 0; i < ROB_DEPTH; i++) doFinish((i + 2) % ROB_DEPTH);
    retCheck('0, "R7");                 // finished but speculative head
    resolve(4'b0001, 1'b0);
    retCheck(2'b11, "R7");
    retCheck('0, "R7");                 // next pair still under 0010
    resolve(4'b0010, 1'b1);
    retCheck(2'b11, "R8");              // squashed pair uses both lanes
    retCheck(2'b11, "R8");              // then the good pair
    retCheck('0, "R6");                 // empty

    // R3 stalled request left tail at index 2; squash unfinished entries (R8)
    alloc(1, 20, 0, 4'b0100, '0, 0, 0, 1, 2);
    alloc(1, 21, 0, 4'b0100, '0, 0, 0, 1, 3);
    retCheck('0, "R8");
    resolve(4'b0100, 1'b1);
    retCheck(2'b11, "R8");

    // R11 same-cycle resolution applies to incoming entry
    alloc(1, 22, 0, 4'b1000, '0, 1, 0, 1, 4);
    brValid = 1'b1; brMask = 4'b1000; brMispredict = 1'b0;
    doFinish(4);
    retCheck(2'b01, "R11");
    alloc(1, 23, 0, 4'b1000, '0, 0, 0, 1, 5);
    brValid = 1'b1; brMask = 4'b1000; brMispredict = 1'b1;
    retCheck(2'b01, "R11");             // squashed at entry, drains unfinished
    retCheck('0, "R11");

    check(expQ.size() == 0, "R9", "items left in scoreboard", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule